// File: doc/BRIEF.md
# MII Management Register Bridge

This block sits between a CPU register port and a built-in model of up to 32 PHY devices, each holding 32 sixteen-bit registers. Software uses two 32-bit registers. The command register holds the PHY address, the register number, a write flag and a busy flag. The data register holds the 16-bit value. A command written with the busy flag set performs one transfer: a write stores the data register into the selected PHY register, and a read copies the selected PHY register into the data register. The busy flag then clears by itself, and software polls it.

The PHY model also produces the side effects software expects from a real transceiver. A write to the basic control register clears its self-clearing reset and restart bits. If auto-negotiation is enabled and has not yet completed, the write marks it complete at once and zeroes the link-partner ability register. No serial management frames are generated.

A three-state machine runs each transfer. In IDLE it waits. A command with the busy flag set (start) moves it to EXEC. EXEC performs the register-file access and always moves to DONE. DONE clears the busy flag and always returns to IDLE.

Top module: `mii_mgmt_bridge`

## Requirements
- R1: A command-register write (wr_sel=0) whose bit 0 (busy) is 0 stores bits 15:0 unchanged, touches no PHY register, and busy stays 0.
- R2: A command-register write with bit 0 set starts a transfer. busy reads 1 in the two cycles after the write edge and 0 from the third. Afterwards the command register holds the written value with bit 0 cleared.
- R3: With command bit 1 (write) set, the data register bits 15:0 are stored into register bits 10:6 of PHY bits 15:11, and the data register keeps its value.
- R4: With command bit 1 clear, the selected PHY register is copied into the data register. Bits 31:16 of both CPU registers always read 0, and rd_sel=0 returns the command register while rd_sel=1 returns the data register.
- R5: A write to PHY register 0 (control) stores the value with bit 15 (reset) and bit 9 (restart auto-negotiation) forced to 0.
- R6: A control write with bit 12 (auto-negotiation enable) set, while bit 5 of register 1 (auto-negotiation complete) is 0, sets that bit and clears register 5 (link-partner ability) to 0 in the same access. If bit 5 is already 1, register 5 is left unchanged.
- R7: While busy is 1, CPU writes to either register are ignored.
- R8: After reset both CPU registers read 0 and busy is 0. PHY 0 holds defaults: reg0=0x1140, reg1=0x7949, reg2=0x0141, reg3=0x0DD1, reg4=0x01E1, reg5=0xC1E1 and reg15=0x3000 (gigabit full-duplex ability). Every other register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_sel | input | 1 | Write target: 0 command register, 1 data register |
| wr_data | input | 32 | CPU write value |
| rd_sel | input | 1 | Read source: 0 command register, 1 data register |
| rd_data | output | 32 | Selected register value (combinational) |
| busy | output | 1 | Transfer in progress (command register bit 0) |

## Verification
The assertions check these behaviours on every cycle:
- busy lasts exactly two cycles and is 1 exactly when the state machine is not IDLE.
- Command fields stay frozen while busy.
- A write transfer leaves the data register untouched.
- A read of the control register never returns the reset or restart bit.

Only the bench scenarios can show the rest:
- The reset defaults.
- Correct routing to a given PHY and register.
- The one-time auto-negotiation side effect and its absence on a second write.
- That writes attempted while busy never reach the register file.

The bench shows these by reading back through the command and data registers.

// File: rtl/mii_bridge_pkg.sv
package mii_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } acc_state_e;

    // command register field positions
    localparam int CMD_BUSY_BIT  = 0;
    localparam int CMD_WRITE_BIT = 1;
    localparam int CMD_REG_LSB   = 6;
    localparam int CMD_PHY_LSB   = 11;
    localparam int CMD_FIELD_W   = 5;

    // PHY register indices and bits with side effects
    localparam int REG_CTRL      = 0;
    localparam int REG_STAT      = 1;
    localparam int REG_LPA       = 5;
    localparam int CTRL_RST_BIT  = 15;
    localparam int CTRL_ANEN_BIT = 12;
    localparam int CTRL_RSTRT_BIT = 9;
    localparam int STAT_ANOK_BIT = 5;

    function automatic logic [15:0] phy0_default(input int idx);
        logic [15:0] v;
        case (idx)
            0:       v = 16'h1140;
            1:       v = 16'h7949;
            2:       v = 16'h0141;
            3:       v = 16'h0DD1;
            4:       v = 16'h01E1;
            5:       v = 16'hC1E1;
            15:      v = 16'h3000;
            default: v = 16'h0000;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mii_cmd_regs.sv
module mii_cmd_regs
    import mii_bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [15:0] wr_val,
    input  logic        done,
    input  logic        cap_en,
    input  logic [15:0] cap_val,
    output logic [15:0] cmd_q,
    output logic [15:0] data_q,
    output logic        start
);

    logic accept;

    assign accept = wr_en && !cmd_q[CMD_BUSY_BIT];
    assign start  = accept && !wr_sel && wr_val[CMD_BUSY_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept && !wr_sel) begin
            cmd_q <= wr_val;
        end else if (done) begin
            cmd_q[CMD_BUSY_BIT] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept && wr_sel) begin
            data_q <= wr_val;
        end else if (cap_en) begin
            data_q <= cap_val;
        end
    end

endmodule

// File: rtl/mii_access_fsm.sv
module mii_access_fsm
    import mii_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output acc_state_e state,
    output logic       exec_en,
    output logic       done
);

    acc_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_EXEC;
            ST_EXEC: nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        exec_en = 1'b0;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_EXEC: exec_en = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mii_phy_model.sv
module mii_phy_model
    import mii_bridge_pkg::*;
#(
    parameter int  REG_COUNT     = 32,
    parameter bit  LOAD_DEFAULTS = 1'b0,
    localparam int RW            = $clog2(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          exec_en,
    input  logic          exec_wr,
    input  logic [RW-1:0] reg_sel,
    input  logic [15:0]   wval,
    output logic [15:0]   rval
);

    logic [15:0] regs_q [REG_COUNT];
    logic        hit;
    logic        is_ctrl;
    logic        an_kick;
    logic [15:0] store_val;

    assign hit     = sel && exec_en && exec_wr;
    assign is_ctrl = (reg_sel == RW'(REG_CTRL));
    assign an_kick = hit && is_ctrl && wval[CTRL_ANEN_BIT]
                     && !regs_q[REG_STAT][STAT_ANOK_BIT];

    always_comb begin
        store_val = wval;
        if (is_ctrl) begin
            store_val[CTRL_RST_BIT]   = 1'b0;
            store_val[CTRL_RSTRT_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                regs_q[i] <= LOAD_DEFAULTS ? phy0_default(i) : 16'h0000;
            end
        end else begin
            if (hit) begin
                regs_q[reg_sel] <= store_val;
            end
            if (an_kick) begin
                regs_q[REG_STAT][STAT_ANOK_BIT] <= 1'b1;
                regs_q[REG_LPA] <= 16'h0000;
            end
        end
    end

    assign rval = regs_q[reg_sel];

endmodule

// File: rtl/mii_mgmt_bridge.sv
module mii_mgmt_bridge
    import mii_bridge_pkg::*;
#(
    parameter int  PHY_COUNT = 32,
    parameter int  REG_COUNT = 32,
    localparam int PW        = $clog2(PHY_COUNT),
    localparam int RW        = $clog2(REG_COUNT)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        busy
);

    logic [15:0] cmd_q;
    logic [15:0] data_q;
    logic        start;
    logic        exec_en;
    logic        done;
    acc_state_e  fsm_state;
    logic [PW-1:0] phy_idx;
    logic [RW-1:0] reg_idx;
    logic [15:0] phy_rd [PHY_COUNT];
    logic [15:0] sel_rd;
    logic        unused_hi;

    assign unused_hi = ^wr_data[31:16];
    assign phy_idx   = cmd_q[CMD_PHY_LSB +: PW];
    assign reg_idx   = cmd_q[CMD_REG_LSB +: RW];
    assign sel_rd    = phy_rd[phy_idx];

    mii_cmd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_val  (wr_data[15:0]),
        .done    (done),
        .cap_en  (exec_en && !cmd_q[CMD_WRITE_BIT]),
        .cap_val (sel_rd),
        .cmd_q   (cmd_q),
        .data_q  (data_q),
        .start   (start)
    );

    mii_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .state   (fsm_state),
        .exec_en (exec_en),
        .done    (done)
    );

    for (genvar p = 0; p < PHY_COUNT; p++) begin : g_phy
        mii_phy_model #(
            .REG_COUNT     (REG_COUNT),
            .LOAD_DEFAULTS (p == 0)
        ) u_phy (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (phy_idx == PW'(p)),
            .exec_en (exec_en),
            .exec_wr (cmd_q[CMD_WRITE_BIT]),
            .reg_sel (reg_idx),
            .wval    (data_q),
            .rval    (phy_rd[p])
        );
    end

    assign busy    = cmd_q[CMD_BUSY_BIT];
    assign rd_data = rd_sel ? {16'h0000, data_q} : {16'h0000, cmd_q};

endmodule

// File: rtl/mii_mgmt_bridge_chk.sv
module mii_mgmt_bridge_chk
    import mii_bridge_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic [15:0] cmd_q,
    input logic [15:0] data_q,
    input acc_state_e  fsm_state
);

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    p_busy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    p_state_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (fsm_state != ST_IDLE));

    p_cmd_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q[15:1]));

    p_data_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_EXEC && cmd_q[CMD_WRITE_BIT]) |=> $stable(data_q));

    p_ctrl_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_EXEC && !cmd_q[CMD_WRITE_BIT]
         && cmd_q[CMD_REG_LSB +: CMD_FIELD_W] == 5'd0)
        |=> (!data_q[CTRL_RST_BIT] && !data_q[CTRL_RSTRT_BIT]));

endmodule

bind mii_mgmt_bridge mii_mgmt_bridge_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cmd_q     (cmd_q),
    .data_q    (data_q),
    .fsm_state (fsm_state)
);

// File: tb/mii_mgmt_bridge_tb_top.sv
module mii_mgmt_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;

    logic [31:0] seen_cmd, seen_data;
    logic        seen_busy;

    // behavioural reference state
    int m_phy [32][32];
    int m_cmd, m_data, m_pend;

    always #4 clk = ~clk;

    mii_mgmt_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int dflt(input int r);
        case (r)
            0: return 'h1140; 1: return 'h7949; 2: return 'h0141; 3: return 'h0DD1;
            4: return 'h01E1; 5: return 'hC1E1; 15: return 'h3000;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < 32; p++)
                for (int r = 0; r < 32; r++)
                    m_phy[p][r] = (p == 0) ? dflt(r) : 0;
            m_cmd = 0; m_data = 0; m_pend = 0;
        end else begin
            automatic bit was_busy = (m_pend > 0);
            if (m_pend == 2) begin
                automatic int pa = (m_cmd >> 11) & 31;
                automatic int ra = (m_cmd >> 6) & 31;
                if (m_cmd & 2) begin
                    automatic int v = m_data;
                    if (ra == 0) begin
                        v = v & ~'h8200;
                        if ((v & 'h1000) && !(m_phy[pa][1] & 'h20)) begin
                            m_phy[pa][1] = m_phy[pa][1] | 'h20;
                            m_phy[pa][5] = 0;
                        end
                    end
                    m_phy[pa][ra] = v;
                end else begin
                    m_data = m_phy[pa][ra];
                end
            end
            if (m_pend > 0) begin
                m_pend--;
                if (m_pend == 0) m_cmd = m_cmd & ~1;
            end
            if (wr_en && !was_busy) begin
                if (wr_sel) m_data = int'(wr_data & 32'hFFFF);
                else begin
                    m_cmd = int'(wr_data & 32'hFFFF);
                    if (wr_data[0]) m_pend = 2;
                end
            end
        end
    end

    always @(negedge clk) begin
        rd_sel = 1'b0;
        #1 seen_cmd = rd_data;
        seen_busy = busy;
        rd_sel = 1'b1;
        #1 seen_data = rd_data;
        if (cmp_on) begin
            chk("R2 busy model", {31'b0, seen_busy}, {31'b0, m_pend > 0});
            chk("R2 command model", seen_cmd, m_cmd);
            chk("R4 data model", seen_data, m_data);
        end
    end

    task automatic cpu_wr(input logic sel, input logic [31:0] v);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cmd(input int pa, input int ra, input bit w, input bit go);
        return {16'h0, pa[4:0], ra[4:0], 4'b0, w, go};
    endfunction

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk); #3;
    endtask

    task automatic phy_wr(input int pa, input int ra, input logic [15:0] v);
        cpu_wr(1'b1, {16'h0, v});
        cpu_wr(1'b0, cmd(pa, ra, 1, 1));
        settle();
    endtask

    task automatic phy_rd(input int pa, input int ra, output logic [15:0] v);
        cpu_wr(1'b0, cmd(pa, ra, 0, 1));
        settle();
        v = seen_data[15:0];
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        #22 rst_n = 1'b1;
        @(negedge clk); #3;
        cmp_on = 1;
        // R8 reset state
        chk("R8 command reset", seen_cmd, 32'h0);
        chk("R8 data reset", seen_data, 32'h0);
        chk("R8 busy reset", {31'b0, seen_busy}, 32'h0);
        phy_rd(0, 15, v); chk("R8 phy0 reg15", {16'h0, v}, 32'h3000);
        phy_rd(0, 0, v);  chk("R8 phy0 reg0", {16'h0, v}, 32'h1140);
        phy_rd(0, 5, v);  chk("R8 phy0 reg5", {16'h0, v}, 32'hC1E1);
        phy_rd(1, 15, v); chk("R8 phy1 reg15", {16'h0, v}, 32'h0);

        // R2 busy timing and completed command value
        cpu_wr(1'b0, cmd(0, 2, 0, 1));
        @(negedge clk); #3; chk("R2 busy cycle1", {31'b0, seen_busy}, 32'h1);
        @(negedge clk); #3; chk("R2 busy cycle2", {31'b0, seen_busy}, 32'h1);
        @(negedge clk); #3; chk("R2 busy cleared", {31'b0, seen_busy}, 32'h0);
        chk("R2 command after", seen_cmd, cmd(0, 2, 0, 0));
        chk("R4 read phy0 reg2", seen_data, 32'h0141);

        // R3 write then read back; data register kept
        phy_wr(7, 20, 16'hBEEF);
        chk("R3 data kept", seen_data, 32'hBEEF);
        phy_rd(7, 20, v); chk("R3 readback", {16'h0, v}, 32'hBEEF);
        phy_rd(20, 7, v); chk("R3 other slot", {16'h0, v}, 32'h0);

        // R4 upper bits read 0
        cpu_wr(1'b1, 32'hFFFF_ABCD);
        @(negedge clk); #3; chk("R4 upper zero", seen_data, 32'h0000_ABCD);

        // R1 command without busy bit
        cpu_wr(1'b1, 32'h4321);
        cpu_wr(1'b0, cmd(2, 7, 1, 0) | 32'h3C);
        @(negedge clk); #3;
        chk("R1 busy low", {31'b0, seen_busy}, 32'h0);
        chk("R1 command stored", seen_cmd, cmd(2, 7, 1, 0) | 32'h3C);
        settle();
        phy_rd(2, 7, v); chk("R1 phy untouched", {16'h0, v}, 32'h0);

        // R5 and R6 on a fresh PHY
        phy_wr(3, 5, 16'h1234);
        phy_wr(3, 0, 16'h9340);
        phy_rd(3, 0, v); chk("R5 ctrl bits cleared", {16'h0, v}, 32'h1140);
        phy_rd(3, 1, v); chk("R6 an complete set", {16'h0, v}, 32'h0020);
        phy_rd(3, 5, v); chk("R6 partner cleared", {16'h0, v}, 32'h0);
        phy_wr(3, 5, 16'h5555);
        phy_wr(3, 0, 16'h1000);
        phy_rd(3, 5, v); chk("R6 no repeat", {16'h0, v}, 32'h5555);
        phy_wr(0, 0, 16'h1200);
        phy_rd(0, 1, v); chk("R6 phy0 status", {16'h0, v}, 32'h7969);
        phy_rd(0, 5, v); chk("R6 phy0 partner", {16'h0, v}, 32'h0);
        phy_wr(4, 0, 16'h8200);
        phy_rd(4, 0, v); chk("R5 reset restart only", {16'h0, v}, 32'h0);
        phy_rd(4, 1, v); chk("R6 no enable no effect", {16'h0, v}, 32'h0);

        // R7 writes while busy are ignored
        cpu_wr(1'b1, 32'h1111);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = cmd(9, 4, 1, 1);
        @(posedge clk); #2;
        wr_sel = 1'b1; wr_data = 32'h2222;
        @(posedge clk); #2;
        wr_sel = 1'b0; wr_data = cmd(9, 6, 1, 1);
        @(posedge clk); #2;
        wr_en = 1'b0;
        @(negedge clk); #3;
        chk("R7 command kept", seen_cmd, cmd(9, 4, 1, 0));
        chk("R7 data kept", seen_data, 32'h1111);
        phy_rd(9, 4, v); chk("R7 target value", {16'h0, v}, 32'h1111);
        phy_rd(9, 6, v); chk("R7 second untouched", {16'h0, v}, 32'h0);

        repeat (4) @(posedge clk);
        @(negedge clk); #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule